// File: doc/BRIEF.md
# Per-Channel Threshold Alarm Monitor

This block watches a stream of finished conversion results from a multi-channel converter. Each channel has two 10-bit limits: an upper limit and a lower limit. When a result arrives, the block compares it with the limits of its own channel. It sets that channel's over-limit flag if the result is above the upper limit, and its under-limit flag if the result is below the lower limit. A single registered summary output is high whenever any flag is set, so it can drive an interrupt or a GPIO pin directly.

A simple write port loads the limits. Each write names a channel, selects upper or lower, and carries the value. After reset the upper limits are all ones and the lower limits are all zeros, so no alarm can fire until software narrows a window. A parameter sets the result resolution to 12, 10 or 8 bits:
- 12-bit results are compared on their ten most significant bits.
- 10-bit results are compared whole.
- 8-bit results are compared against the top eight bits of each limit, and the two lowest limit bits have no effect.

Top module: `chan_limit_monitor`

## Requirements
- R1: After reset all flags and the summary output are low, every upper limit is all ones and every lower limit is all zeros, so a conversion of any value on an unwritten channel raises no flag.
- R2: With 12-bit results, bits 11:2 of the result form the compared value and bits 1:0 have no effect.
- R3: The over-limit flag of a channel is set when the compared value is strictly greater than that channel's upper limit; equality does not set it.
- R4: The under-limit flag of a channel is set when the compared value is strictly less than that channel's lower limit; equality does not set it.
- R5: A channel's flags are rewritten only in the clock after a conversion strobe for that channel, and hold their value otherwise, including when other channels convert.
- R6: A limit write with `lim_we` high stores `lim_data` into the upper limit (`lim_upper`=1) or the lower limit (`lim_upper`=0) of channel `lim_ch` only, and it applies to later conversions of that channel.
- R7: A limit write in the same cycle as a conversion of the same channel does not affect that conversion; the conversion uses the old limit.
- R8: `alarm_any` equals the OR of all over-limit and under-limit flags, delayed by one clock.
- R9: With 8-bit results, all eight result bits are compared with limit bits 9:2, and limit bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | One-cycle strobe marking a finished conversion |
| conv_ch | input | CH_W (4) | Channel of the conversion |
| conv_data | input | RES_BITS (12) | Conversion result |
| lim_we | input | 1 | Limit write enable |
| lim_ch | input | CH_W (4) | Channel whose limit is written |
| lim_upper | input | 1 | 1 selects the upper limit, 0 the lower limit |
| lim_data | input | LIM_W (10) | Limit value |
| over_flag | output | NUM_CH (16) | Per-channel over-limit flags |
| under_flag | output | NUM_CH (16) | Per-channel under-limit flags |
| alarm_any | output | 1 | Registered OR of all flags |

## Verification
The assertions check four things on every cycle:
- A flag never changes for a channel that was not just converted.
- A limit write alone never disturbs any flag.
- The summary output only rises after some flag was set.
- The summary output falls once all flags are clear.

The exact value of each comparison needs the bench's scenarios, because it depends on stored limits and result data: the equality boundaries, the ignored low result bits, the old-limit rule for a write that collides with a conversion, and the 8-bit limit mapping.

// File: rtl/chan_limit_monitor.sv
module chan_limit_monitor #(
  parameter int NUM_CH   = 16,
  parameter int RES_BITS = 12,
  parameter int LIM_W    = 10,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int CMP_W   = (RES_BITS < LIM_W) ? RES_BITS : LIM_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_valid,
  input  logic [CH_W-1:0]     conv_ch,
  input  logic [RES_BITS-1:0] conv_data,
  input  logic                lim_we,
  input  logic [CH_W-1:0]     lim_ch,
  input  logic                lim_upper,
  input  logic [LIM_W-1:0]    lim_data,
  output logic [NUM_CH-1:0]   over_flag,
  output logic [NUM_CH-1:0]   under_flag,
  output logic                alarm_any
);

  logic [LIM_W-1:0] upper_lim [NUM_CH];
  logic [LIM_W-1:0] lower_lim [NUM_CH];

  logic [CMP_W-1:0] sample_cmp, upper_cmp, lower_cmp;
  logic [LIM_W-1:0] upper_sel, lower_sel;

  assign sample_cmp = conv_data[RES_BITS-1 -: CMP_W];
  assign upper_sel  = upper_lim[conv_ch];
  assign lower_sel  = lower_lim[conv_ch];
  assign upper_cmp  = upper_sel[LIM_W-1 -: CMP_W];
  assign lower_cmp  = lower_sel[LIM_W-1 -: CMP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        upper_lim[i] <= '1;
        lower_lim[i] <= '0;
      end
    end else if (lim_we) begin
      if (lim_upper) upper_lim[lim_ch] <= lim_data;
      else           lower_lim[lim_ch] <= lim_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      over_flag  <= '0;
      under_flag <= '0;
    end else if (conv_valid) begin
      over_flag[conv_ch]  <= sample_cmp > upper_cmp;
      under_flag[conv_ch] <= sample_cmp < lower_cmp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_any <= 1'b0;
    else        alarm_any <= |{over_flag, under_flag};
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(conv_valid && conv_ch == CH_W'(g)) |=> $stable(over_flag[g]) && $stable(under_flag[g]));
  end

  assert_write_no_flag_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_we && !conv_valid) |=> $stable(over_flag) && $stable(under_flag));

  assert_summary_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_any) |-> $past((|over_flag) || (|under_flag)));

  assert_summary_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (over_flag == '0 && under_flag == '0) |=> !alarm_any);

endmodule

// File: tb/chan_limit_monitor_test.sv
`timescale 1ns/1ps
module chan_limit_monitor_test;
  logic clk = 0, rst_n = 0;
  logic conv_valid = 0, lim_we = 0, lim_upper = 0;
  logic [3:0] conv_ch = 0, lim_ch = 0;
  logic [11:0] conv_data = 0;
  logic [7:0] conv_data8 = 0;
  logic [9:0] lim_data = 0;
  logic [15:0] over_flag, under_flag, over8, under8;
  logic alarm_any, alarm8;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  chan_limit_monitor uut (.clk, .rst_n, .conv_valid, .conv_ch, .conv_data, .lim_we, .lim_ch,
    .lim_upper, .lim_data, .over_flag, .under_flag, .alarm_any);

  chan_limit_monitor #(.RES_BITS(8)) uut8 (.clk, .rst_n, .conv_valid, .conv_ch, .conv_data(conv_data8),
    .lim_we, .lim_ch, .lim_upper, .lim_data, .over_flag(over8), .under_flag(under8), .alarm_any(alarm8));

  // {channel, result, expected over, expected under}
  localparam logic [17:0] VEC [7] = '{
    {4'd3, 12'd2403, 1'b0, 1'b0},
    {4'd3, 12'd2404, 1'b1, 1'b0},
    {4'd3, 12'd400,  1'b0, 1'b0},
    {4'd3, 12'd399,  1'b0, 1'b1},
    {4'd5, 12'd4095, 1'b0, 1'b0},
    {4'd5, 12'd0,    1'b0, 1'b0},
    {4'd3, 12'd2000, 1'b0, 1'b0}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] ch, input logic up, input logic [9:0] v);
    @(negedge clk);
    lim_we = 1; lim_ch = ch; lim_upper = up; lim_data = v;
    @(negedge clk);
    lim_we = 0;
  endtask

  task automatic conv(input logic [3:0] ch, input logic [11:0] d, input logic [7:0] d8);
    @(negedge clk);
    conv_valid = 1; conv_ch = ch; conv_data = d; conv_data8 = d8;
    @(negedge clk);
    conv_valid = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12 rst_n = 1;
    @(negedge clk);
    check("R1 over flags", over_flag, 0);
    check("R1 under flags", under_flag, 0);
    check("R1 summary", alarm_any, 0);
    conv(0, 12'hFFF, 8'hFF);
    check("R1 max result", {over_flag[0], under_flag[0]}, 0);
    conv(0, 12'h000, 8'h00);
    check("R1 zero result", {over_flag[0], under_flag[0]}, 0);

    wr(3, 1, 600);
    wr(3, 0, 100);
    for (int i = 0; i < 7; i++) begin
      conv(VEC[i][17:14], VEC[i][13:2], 8'd0);
      check($sformatf("R2 R3 R4 vector %0d", i),
            {over_flag[VEC[i][17:14]], under_flag[VEC[i][17:14]]}, VEC[i][1:0]);
    end

    conv(3, 12'd2404, 8'd0);
    check("R8 summary delayed", alarm_any, 0);
    @(negedge clk);
    check("R8 summary set", alarm_any, 1);
    conv(7, 12'd1000, 8'd0);
    check("R5 other channel holds", over_flag[3], 1);
    wr(3, 0, 50);
    check("R5 write holds flag", over_flag[3], 1);
    conv(3, 12'd2000, 8'd0);
    check("R5 own conversion clears", over_flag[3], 0);
    @(negedge clk);
    check("R8 summary cleared", alarm_any, 0);

    wr(4, 0, 200);
    conv(4, 12'd600, 8'd0);
    check("R6 written channel", under_flag[4], 1);
    conv(3, 12'd600, 8'd0);
    check("R6 other channel untouched", under_flag[3], 0);

    @(negedge clk);
    lim_we = 1; lim_ch = 6; lim_upper = 1; lim_data = 50;
    conv_valid = 1; conv_ch = 6; conv_data = 12'd240;
    @(negedge clk);
    lim_we = 0; conv_valid = 0;
    check("R7 old limit used", over_flag[6], 0);
    conv(6, 12'd240, 8'd0);
    check("R7 new limit later", over_flag[6], 1);

    wr(2, 1, 10'd403);
    wr(2, 0, 10'd203);
    conv(2, 12'd0, 8'd101);
    check("R9 above upper", {over8[2], under8[2]}, 2);
    conv(2, 12'd0, 8'd100);
    check("R9 equal upper", {over8[2], under8[2]}, 0);
    conv(2, 12'd0, 8'd49);
    check("R9 below lower", {over8[2], under8[2]}, 1);
    conv(2, 12'd0, 8'd50);
    check("R9 equal lower", {over8[2], under8[2]}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule